// File: doc/BRIEF.md
# Exponential Retry Backoff Controller

This block paces the retries of a contended atomic operation such as a compare-and-swap that keeps losing. It keeps a backoff multiplier. The multiplier goes back to one whenever a new operation is announced. Each failure reported while the operation is live produces exactly one pause request toward a downstream pause unit. The request carries the full wait as a single cycle count, equal to the multiplier times 128. The multiplier then grows for the next failure.

Growth is by doubling. The doubling is skipped once the multiplier has gone past a limit of 4096, so the multiplier settles at 8192 and the largest wait is 1,048,576 cycles. The controller reports busy from the moment a wait is issued until the pause unit signals completion. A success pulse closes the operation. Failures are then ignored until the next start pulse.

Top module: `retry_backoff_ctrl`

## Requirements
- R1: After a synchronous active-low reset, busy_o, pause_req_o and pause_amt_o are all zero. A failure pulse seen before any operation-start pulse produces no request.
- R2: An operation-start pulse sets the multiplier to 1, so the first failure afterwards requests 128 cycles.
- R3: Each accepted failure doubles the multiplier used by the next failure, giving requests of 128, 256, 512 and so on.
- R4: The doubling happens only when the multiplier is 4096 or less. From 8192 onward every request carries 1,048,576 cycles, and the multiplier never exceeds 8192.
- R5: An accepted failure gives a one-cycle pause_req_o pulse on the cycle after the failure pulse. pause_amt_o carries the multiplier value from before the doubling, shifted left by 7, and holds that value until the next request.
- R6: busy_o rises together with pause_req_o and stays high until pause_done_i. It falls on the cycle after pause_done_i is seen.
- R7: A failure pulse while busy_o is high issues nothing and leaves the multiplier unchanged.
- R8: A success pulse ends the operation. Later failures are ignored until the next start pulse, which again begins at a multiplier of 1.
- R9: When a start pulse or a success pulse falls in the same cycle as a failure pulse, the failure is ignored. A start pulse in that cycle still resets the multiplier to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start_i | input | 1 | Pulse: a new atomic operation begins |
| fail_i | input | 1 | Pulse: the current attempt failed |
| success_i | input | 1 | Pulse: the current attempt succeeded |
| pause_done_i | input | 1 | Pause unit reports the wait has elapsed |
| busy_o | output | 1 | A wait is outstanding |
| pause_req_o | output | 1 | One-cycle pause request strobe |
| pause_amt_o | output | 21 | Wait length in cycles for the request |

## Verification
The embedded assertions check several rules on every cycle:
- the multiplier is reset on a start pulse;
- the multiplier doubles below the limit and holds above it, and its bound is never exceeded;
- the issued amount is scaled from the multiplier value from before the doubling;
- the request is a single-cycle pulse that coincides with busy rising;
- busy holds until the pause unit reports done;
- no request follows a start pulse or an idle state.

Only the bench scenarios can show the full sequence of amounts from a start pulse up to saturation. They also show that a failure ignored during busy leaves the next amount unchanged, that the operation stays closed after success, and how simultaneous pulses resolve under random traffic.

// File: rtl/backoff_pkg.sv
// Package: backoff_pkg
// Shared types for the retry backoff controller.
// Assumes: a single requester; the sequencer state is the only shared enum.
package backoff_pkg;

    // Sequencer states: operation live/closed crossed with wait outstanding/not
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,   // no live operation, no wait outstanding
        ST_ARMED     = 2'd1,   // live operation, ready to accept a failure
        ST_WAIT_LIVE = 2'd2,   // wait outstanding, operation still live
        ST_WAIT_OVER = 2'd3    // wait outstanding, operation already closed
    } bo_state_e;

endpackage

// File: rtl/backoff_seq.sv
// Module: backoff_seq
// Tracks whether an operation is live and whether a wait is outstanding.
// It decides when a failure is accepted and turns into a pause request.
// Assumes: the input pulses are synchronous to clk. Start has priority over
// success, and both have priority over failure in the same cycle.
module backoff_seq
    import backoff_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic fail_i,
    input  logic success_i,
    input  logic done_i,
    output logic issue_o,
    output logic busy_o
);

    bo_state_e state_q;
    bo_state_e state_d;

    logic close_req;

    // Purpose: a success only closes the operation when no start overrides it
    assign close_req = success_i & ~start_i;

    // Purpose: a failure is accepted only when armed and no start or success competes
    assign issue_o = (state_q == ST_ARMED) & fail_i & ~start_i & ~success_i;

    // Purpose: busy is a pure decode of the registered state
    assign busy_o = (state_q == ST_WAIT_LIVE) | (state_q == ST_WAIT_OVER);

    // Purpose: next-state selection for the sequencer
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (start_i)        state_d = ST_ARMED;
                else if (success_i) state_d = ST_IDLE;
                else if (fail_i)    state_d = ST_WAIT_LIVE;
            end
            ST_WAIT_LIVE: begin
                if (done_i) state_d = close_req ? ST_IDLE : ST_ARMED;
                else        state_d = close_req ? ST_WAIT_OVER : ST_WAIT_LIVE;
            end
            ST_WAIT_OVER: begin
                if (done_i) state_d = start_i ? ST_ARMED : ST_IDLE;
                else        state_d = start_i ? ST_WAIT_LIVE : ST_WAIT_OVER;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // R8: an idle sequencer never enters a wait on the next cycle
    assert_idle_no_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q != ST_WAIT_LIVE && state_q != ST_WAIT_OVER));

    // R6: an outstanding wait without done stays outstanding
    assert_wait_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_i) |=> busy_o);

    // R6: done while waiting always releases the wait
    assert_done_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && done_i) |=> !busy_o);

endmodule

// File: rtl/backoff_mult.sv
// Module: backoff_mult
// Holds the backoff multiplier. Start reloads it to one. An accepted
// failure doubles it while it is at or below LIMIT, and leaves it
// unchanged above LIMIT.
// Assumes: MULT_W is wide enough to hold 2*LIMIT.
module backoff_mult #(
    parameter int MULT_W = 14,
    parameter int LIMIT  = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              issue_i,
    output logic [MULT_W-1:0] mult_o
);

    localparam logic [MULT_W-1:0] LIMIT_V = MULT_W'(LIMIT);
    localparam logic [MULT_W-1:0] ONE_V   = MULT_W'(1);
    localparam logic [MULT_W-1:0] CEIL_V  = MULT_W'(2 * LIMIT);

    logic [MULT_W-1:0] mult_q;
    logic [MULT_W-1:0] mult_d;
    logic              may_grow;

    // Purpose: growth is allowed only while the multiplier is not past the limit
    assign may_grow = (mult_q <= LIMIT_V);

    // Purpose: choose reload, doubling, or hold
    always_comb begin
        mult_d = mult_q;
        if (start_i)                  mult_d = ONE_V;
        else if (issue_i && may_grow) mult_d = {mult_q[MULT_W-2:0], 1'b0};
    end

    // Purpose: multiplier register; its reset value matches a fresh start
    always_ff @(posedge clk) begin
        if (!rst_n) mult_q <= ONE_V;
        else        mult_q <= mult_d;
    end

    assign mult_o = mult_q;

    // R2: a start pulse leaves the multiplier at one
    assert_start_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (mult_q == ONE_V));

    // R3: an accepted failure at or below the limit doubles the multiplier
    assert_double_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !start_i && mult_q <= LIMIT_V) |=> (mult_q == ($past(mult_q) << 1)));

    // R4: past the limit the multiplier holds
    assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !start_i && mult_q > LIMIT_V) |=> $stable(mult_q));

    // R7: with no start and no issue, the multiplier is unchanged
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_i && !start_i) |=> $stable(mult_q));

    // R4: the multiplier never exceeds twice the limit
    always_ff @(posedge clk) begin
        if (rst_n) begin
            assert_no_overflow_R4: assert (mult_q <= CEIL_V && mult_q != '0);
        end
    end

endmodule

// File: rtl/backoff_issue.sv
// Module: backoff_issue
// Registers the pause request strobe and its amount. The amount is the
// multiplier scaled by 2**SCALE_SH and is captured from the multiplier
// value from before the doubling.
// Assumes: issue_i is a single-cycle pulse; the amount holds between requests.
module backoff_issue #(
    parameter int MULT_W   = 14,
    parameter int SCALE_SH = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       issue_i,
    input  logic [MULT_W-1:0]          mult_i,
    output logic                       req_o,
    output logic [MULT_W+SCALE_SH-1:0] amt_o
);

    localparam int AMT_W = MULT_W + SCALE_SH;

    logic [AMT_W-1:0] scaled;
    logic [AMT_W-1:0] amt_q;
    logic             req_q;

    // Purpose: scaling is a fixed wire shift; no shift is needed when SCALE_SH is zero
    generate
        if (SCALE_SH == 0) begin : g_noscale
            assign scaled = mult_i;
        end else begin : g_scale
            assign scaled = {mult_i, {SCALE_SH{1'b0}}};
        end
    endgenerate

    // Purpose: strobe and amount registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            amt_q <= '0;
        end else begin
            req_q <= issue_i;
            if (issue_i) amt_q <= scaled;
        end
    end

    assign req_o = req_q;
    assign amt_o = amt_q;

    // R5: the request is a single-cycle strobe
    assert_req_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q);

    // R5: the amount issued is the multiplier from before the doubling, scaled
    assert_amt_scale_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> (amt_q == AMT_W'($past(mult_i)) << SCALE_SH));

    // R5: between requests the amount holds
    assert_amt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> $stable(amt_q));

endmodule

// File: rtl/retry_backoff_ctrl.sv
// Module: retry_backoff_ctrl
// Top of the retry backoff controller. It paces retries of one contended
// atomic operation. Each accepted failure yields one pause request of
// multiplier*2**SCALE_SH cycles, and the multiplier then doubles up to a
// saturation point.
// Assumes: one requester; pause_done_i is only meaningful while busy_o is high.
module retry_backoff_ctrl #(
    parameter int MULT_W   = 14,
    parameter int LIMIT    = 4096,
    parameter int SCALE_SH = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       op_start_i,
    input  logic                       fail_i,
    input  logic                       success_i,
    input  logic                       pause_done_i,
    output logic                       busy_o,
    output logic                       pause_req_o,
    output logic [MULT_W+SCALE_SH-1:0] pause_amt_o
);

    localparam int AMT_W = MULT_W + SCALE_SH;

    logic              issue;
    logic [MULT_W-1:0] mult;
    logic [AMT_W-1:0]  amt;

    // Purpose: acceptance and busy tracking
    backoff_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (op_start_i),
        .fail_i    (fail_i),
        .success_i (success_i),
        .done_i    (pause_done_i),
        .issue_o   (issue),
        .busy_o    (busy_o)
    );

    // Purpose: multiplier storage and growth
    backoff_mult #(
        .MULT_W (MULT_W),
        .LIMIT  (LIMIT)
    ) u_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (op_start_i),
        .issue_i (issue),
        .mult_o  (mult)
    );

    // Purpose: request strobe and scaled amount
    backoff_issue #(
        .MULT_W   (MULT_W),
        .SCALE_SH (SCALE_SH)
    ) u_issue (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue_i (issue),
        .mult_i  (mult),
        .req_o   (pause_req_o),
        .amt_o   (amt)
    );

    assign pause_amt_o = amt;

    // R6: every request coincides with busy rising
    assert_req_with_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req_o |-> $rose(busy_o));

    // R7: a failure while busy produces no request
    assert_busy_ignores_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && fail_i) |=> !pause_req_o);

    // R9: a start pulse never leads to a request on the next cycle
    assert_start_blocks_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_start_i |=> !pause_req_o);

    // R9: a success pulse never leads to a request on the next cycle
    assert_success_blocks_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        success_i |=> !pause_req_o);

endmodule

// File: tb/retry_backoff_ctrl_bench.sv
module retry_backoff_ctrl_bench;

    localparam int MULT_W = 14;
    localparam int LIMIT  = 4096;
    localparam int SH     = 7;
    localparam int AW     = MULT_W + SH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 1'b0, fail = 1'b0, success = 1'b0, done = 1'b0;
    logic busy, req;
    logic [AW-1:0] amt;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // model state
    bit          m_act, m_busy, m_req;
    int unsigned m_mult;
    int unsigned m_amt;

    always #5 clk = ~clk;

    retry_backoff_ctrl u_retry_backoff_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_start_i   (op_start),
        .fail_i       (fail),
        .success_i    (success),
        .pause_done_i (done),
        .busy_o       (busy),
        .pause_req_o  (req),
        .pause_amt_o  (amt)
    );

    // amount expected for the k-th failure after a start
    function automatic int unsigned exp_amt(int k);
        int unsigned m;
        m = (k >= 13) ? 8192 : (32'd1 << k);
        return m * 128;
    endfunction

    task automatic check(string tag, bit ok, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // apply one cycle of inputs, advance the model, then compare at the next negedge
    task automatic step(bit st, bit fl, bit sc, bit dn, string tag);
        bit issue;
        op_start = st; fail = fl; success = sc; done = dn;
        issue  = m_act && !m_busy && fl && !st && !sc;
        m_req  = issue;
        if (issue) m_amt = m_mult * 128;
        if (st) m_mult = 1;
        else if (issue && m_mult <= LIMIT) m_mult = m_mult * 2;
        m_busy = m_busy ? !dn : issue;
        m_act  = st ? 1'b1 : (sc ? 1'b0 : m_act);
        @(negedge clk);
        check(tag, {busy, req, amt} == {m_busy, m_req, AW'(m_amt)},
              {busy, req, amt}, {m_busy, m_req, AW'(m_amt)});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_act = 0; m_busy = 0; m_req = 0; m_mult = 1; m_amt = 0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {busy, req, amt} == '0, {busy, req, amt}, 0);
        rst_n = 1'b1;
        step(0, 1, 0, 0, "R1 fail before start");
        step(0, 0, 0, 0, "R1 idle");

        // saturation walk
        step(1, 0, 0, 0, "R2 start");
        for (int k = 0; k < 16; k++) begin
            step(0, 1, 0, 0, k == 0 ? "R2 first fail" : (k <= 13 ? "R3 doubling" : "R4 saturated"));
            check(k < 13 ? "R3 amount" : "R4 amount", req && amt == AW'(exp_amt(k)), amt, exp_amt(k));
            step(0, 0, 0, 0, "R5 strobe drops");
            check("R5 amount held", !req && amt == AW'(exp_amt(k)), amt, exp_amt(k));
            step(0, 0, 0, 1, "R6 done");
            check("R6 busy falls", busy == 1'b0, busy, 0);
        end

        // busy hold and ignored failure
        step(1, 0, 0, 0, "R2 restart");
        step(0, 1, 0, 0, "R2 fail 128");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R6 hold");
        check("R6 busy held", busy == 1'b1, busy, 1);
        step(0, 1, 0, 0, "R7 fail while busy");
        check("R7 no request", req == 1'b0, req, 0);
        step(0, 0, 0, 1, "R6 done");
        step(0, 1, 0, 0, "R7 next amount");
        check("R7 multiplier unchanged", amt == AW'(256), amt, 256);
        step(0, 0, 0, 1, "R6 done");

        // success closes
        step(0, 0, 1, 0, "R8 success");
        step(0, 1, 0, 0, "R8 fail after success");
        check("R8 ignored", req == 1'b0 && busy == 1'b0, {busy, req}, 0);
        step(1, 0, 0, 0, "R8 start again");
        step(0, 1, 0, 0, "R8 restart amount");
        check("R8 multiplier back to one", amt == AW'(128), amt, 128);
        step(0, 0, 0, 1, "R6 done");

        // same-cycle priority
        step(0, 1, 0, 0, "R9 setup");
        step(0, 0, 0, 1, "R9 setup done");
        step(1, 1, 0, 0, "R9 start with fail");
        check("R9 start wins", req == 1'b0, req, 0);
        step(0, 1, 0, 0, "R9 after start");
        check("R9 multiplier reset", amt == AW'(128), amt, 128);
        step(0, 0, 0, 1, "R6 done");
        step(0, 1, 1, 0, "R9 success with fail");
        check("R9 success wins", req == 1'b0 && busy == 1'b0, {busy, req}, 0);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            bit st, fl, sc, dn;
            st = ($urandom % 20) == 0;
            sc = ($urandom % 12) == 0;
            fl = ($urandom % 3) == 0;
            dn = ($urandom % 4) == 0;
            step(st, fl, sc, dn, "R5 random");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule